// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the integer register state of a processor core that runs in several privilege modes. Software names sixteen architectural registers, numbered 0 to 15. The mode field in the low five bits of the current status word picks which physical copy of a register a name refers to. Registers 0 to 7 are common to every mode. Registers 8 to 12 have a second copy that only fast-interrupt mode uses. Registers 13 and 14 have a private pair in each exception mode, so a handler gets its own stack pointer and link register without saving anything first. Register 15 is the program counter. It is not stored here: a read returns the `pc_in` input, and a write is passed out as a branch request.

The block also holds the current status word and five saved-status slots, one for each exception mode. When the core takes an exception, the current status is copied into the slot of the target mode, and the mode field switches to that mode in the same clock. When the core returns from an exception, the current status is reloaded from the slot of the active mode. Deciding which exception to take, and decoding instructions, are handled outside this block.

There are two read ports and one write port. Read data is registered, so it appears one clock after the register number is presented. This matches block RAM with an output register.

Top module: `banked_regfile`

## Requirements
- R1: While reset is held, the current status reads 0x00000013 (supervisor mode), the saved status output reads 0, the branch flag is low and both read-data outputs read 0.
- R2: Registers 0 to 7 are one copy shared by all modes: a value written in one mode is read back in any other mode.
- R3: Registers 8 to 12 written in fast-interrupt mode (mode code 10001) go to a private copy. Every other mode shares a separate common copy of them.
- R4: Registers 13 and 14 have separate copies for fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes. User (10000) and system (11111) modes share one further copy.
- R5: Read data appears on the clock edge after the register number is presented. A read of register 15 returns the value `pc_in` had at that edge.
- R6: A write to register 15 raises `br_valid` for exactly one cycle, with `br_target` equal to the written data, one clock later. No stored register is changed by it.
- R7: Exception entry with a target mode code of an exception mode copies the whole current status into that mode's saved slot. In the same clock, the low five bits of the current status take the target code and the other bits are kept. Entry with any other target code is ignored.
- R8: Exception return loads the current status from the saved slot of the active mode. In user, system or any non-exception mode code, the request is ignored.
- R9: When requests arrive in the same cycle, exception entry wins over return, and return wins over a direct status write. A register write in that cycle uses the bank of the mode in force before the change.
- R10: A direct status write replaces all bits of the current status and leaves the saved slots unchanged.
- R11: `spsr_o` shows the saved slot of the active mode, and reads 0 while the active mode has no slot.
- R12: A read and a write to the same physical register in the same cycle return the old contents. The new value is visible on the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Register number, read port A |
| rd_b_idx | input | 4 | Register number, read port B |
| rd_a_data | output | W | Registered read data, port A |
| rd_b_data | output | W | Registered read data, port B |
| pc_in | input | W | Program counter value returned for register 15 |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | W | Write data |
| br_valid | output | 1 | One-cycle pulse after a write to register 15 |
| br_target | output | W | Data of the last write to register 15 |
| exc_enter | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode code for exception entry |
| exc_return | input | 1 | Exception return request |
| csr_we | input | 1 | Direct write of the current status |
| csr_wdata | input | W | Data for the direct status write |
| cpsr_o | output | W | Current status word |
| spsr_o | output | W | Saved status of the active mode |

## Verification
The bench gives registers 13 and 14 a different value in each of the six banks and reads them all back, including from system mode. A wrong slot offset would make two modes alias one stack pointer. After a write to register 15 from fast-interrupt mode, it confirms that the private register 8 still holds its value. A map that used the raw number as a physical index would overwrite that register. The bench drives entry, return and a status write all in one cycle, together with a register write. A wrong priority would show a wrong mode, and a wrong bank timing would put the stack-pointer write in the abort bank. Return requests in user and system mode, and entry with a non-exception code, must leave the status unchanged. A read issued in the same cycle as a write must return the old value.

// File: rtl/bank_pkg.sv
package bank_pkg;

  localparam int MODE_W = 5;
  localparam int ARCH_W = 4;
  localparam int N_ARCH = 16;
  localparam int PC_NUM = 15;

  localparam int N_SAVED   = 5;
  localparam int FIQ_BASE  = 15;  // private copies of r8..r14 for fast interrupt
  localparam int SP_BASE   = 22;  // r13/r14 pairs for irq, svc, abt, und
  localparam int N_PHYS    = 30;
  localparam int PHYS_W    = $clog2(N_PHYS);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // System mode and any unknown code fall back to the user bank.
  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BK_FIQ;
      M_IRQ:   return BK_IRQ;
      M_SVC:   return BK_SVC;
      M_ABT:   return BK_ABT;
      M_UND:   return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic has_slot(input logic [MODE_W-1:0] m);
    return bank_of(m) != BK_USR;
  endfunction

  function automatic logic [2:0] slot_of(input bank_e b);
    return 3'(b) - 3'd1;
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [ARCH_W-1:0] arch,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);

  bank_e bank;
  logic  hi_fiq;
  logic  sp_lr;

  always_comb begin
    bank   = bank_of(mode);
    is_pc  = arch == ARCH_W'(PC_NUM);
    hi_fiq = (arch >= 4'd8) && (arch <= 4'd12);
    sp_lr  = (arch == 4'd13) || (arch == 4'd14);
    phys   = PHYS_W'(arch);
    if (is_pc) begin
      phys = '0;
    end else if (bank == BK_FIQ && (hi_fiq || sp_lr)) begin
      phys = PHYS_W'(FIQ_BASE) + PHYS_W'(arch) - PHYS_W'(8);
    end else if (sp_lr && bank != BK_USR) begin
      phys = PHYS_W'(SP_BASE)
           + (PHYS_W'(3'(bank) - 3'd2) << 1)
           + PHYS_W'(arch == 4'd14);
    end
  end

endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int W     = 32,
  parameter int DEPTH = 30,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered reads see the array contents before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= mem[raddr_a];
      rdata_b <= mem[raddr_b];
    end
  end

endmodule

// File: rtl/status_unit.sv
module status_unit
  import bank_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] RESET_WORD = W'(M_SVC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_enter,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              exc_return,
  input  logic              csr_we,
  input  logic [W-1:0]      csr_wdata,
  output logic [W-1:0]      cpsr,
  output logic [W-1:0]      spsr_cur
);

  logic [W-1:0] saved [N_SAVED];
  bank_e        cur_bank;
  logic         enter_ok;
  logic         return_ok;
  logic [2:0]   enter_slot;
  logic [2:0]   cur_slot;

  always_comb begin
    cur_bank   = bank_of(cpsr[MODE_W-1:0]);
    cur_slot   = slot_of(cur_bank);
    enter_slot = slot_of(bank_of(exc_mode));
    enter_ok   = exc_enter && has_slot(exc_mode);
    return_ok  = exc_return && (cur_bank != BK_USR);
    spsr_cur   = (cur_bank == BK_USR) ? '0 : saved[cur_slot];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr <= RESET_WORD;
      for (int i = 0; i < N_SAVED; i++) saved[i] <= '0;
    end else if (enter_ok) begin
      saved[enter_slot] <= cpsr;
      cpsr <= {cpsr[W-1:MODE_W], exc_mode};
    end else if (return_ok) begin
      cpsr <= saved[cur_slot];
    end else if (csr_we) begin
      cpsr <= csr_wdata;
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ARCH_W-1:0] rd_a_idx,
  input  logic [ARCH_W-1:0] rd_b_idx,
  output logic [W-1:0]      rd_a_data,
  output logic [W-1:0]      rd_b_data,
  input  logic [W-1:0]      pc_in,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_idx,
  input  logic [W-1:0]      wr_data,
  output logic              br_valid,
  output logic [W-1:0]      br_target,
  input  logic              exc_enter,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              exc_return,
  input  logic              csr_we,
  input  logic [W-1:0]      csr_wdata,
  output logic [W-1:0]      cpsr_o,
  output logic [W-1:0]      spsr_o
);

  localparam int N_PORTS = 3;  // read A, read B, write

  logic [W-1:0]      cpsr_q;
  logic [ARCH_W-1:0] arch_sel [N_PORTS];
  logic [PHYS_W-1:0] phys_sel [N_PORTS];
  logic              pc_sel   [N_PORTS];
  logic [W-1:0]      ram_a, ram_b;
  logic              a_pc_q, b_pc_q;
  logic [W-1:0]      pc_q;

  assign arch_sel[0] = rd_a_idx;
  assign arch_sel[1] = rd_b_idx;
  assign arch_sel[2] = wr_idx;

  genvar p;
  generate
    for (p = 0; p < N_PORTS; p++) begin : g_map
      bank_map u_map (
        .mode  (cpsr_q[MODE_W-1:0]),
        .arch  (arch_sel[p]),
        .phys  (phys_sel[p]),
        .is_pc (pc_sel[p])
      );
    end
  endgenerate

  status_unit #(.W(W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .exc_enter  (exc_enter),
    .exc_mode   (exc_mode),
    .exc_return (exc_return),
    .csr_we     (csr_we),
    .csr_wdata  (csr_wdata),
    .cpsr       (cpsr_q),
    .spsr_cur   (spsr_o)
  );

  gpr_store #(.W(W), .DEPTH(N_PHYS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en && !pc_sel[2]),
    .waddr   (phys_sel[2]),
    .wdata   (wr_data),
    .raddr_a (phys_sel[0]),
    .raddr_b (phys_sel[1]),
    .rdata_a (ram_a),
    .rdata_b (ram_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_pc_q    <= 1'b0;
      b_pc_q    <= 1'b0;
      pc_q      <= '0;
      br_valid  <= 1'b0;
      br_target <= '0;
    end else begin
      a_pc_q   <= pc_sel[0];
      b_pc_q   <= pc_sel[1];
      pc_q     <= pc_in;
      br_valid <= wr_en && pc_sel[2];
      if (wr_en && pc_sel[2]) br_target <= wr_data;
    end
  end

  assign rd_a_data = a_pc_q ? pc_q : ram_a;
  assign rd_b_data = b_pc_q ? pc_q : ram_b;
  assign cpsr_o    = cpsr_q;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import bank_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ARCH_W-1:0] rd_a_idx,
  input logic [W-1:0]      rd_a_data,
  input logic [W-1:0]      pc_in,
  input logic              wr_en,
  input logic [ARCH_W-1:0] wr_idx,
  input logic [W-1:0]      wr_data,
  input logic              br_valid,
  input logic [W-1:0]      br_target,
  input logic              exc_enter,
  input logic [MODE_W-1:0] exc_mode,
  input logic              exc_return,
  input logic              csr_we,
  input logic [W-1:0]      cpsr_o,
  input logic [W-1:0]      spsr_o
);

  logic no_slot_mode;
  assign no_slot_mode = !has_slot(cpsr_o[MODE_W-1:0]);

  // R5
  pc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 4'd15) |=> (rd_a_data == $past(pc_in)));

  // R6
  br_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 4'd15) |=> (br_valid && br_target == $past(wr_data)));

  // R6
  br_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == 4'd15) |=> !br_valid);

  // R7
  entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_enter && has_slot(exc_mode)) |=>
      (cpsr_o[MODE_W-1:0] == $past(exc_mode)) &&
      (cpsr_o[W-1:MODE_W] == $past(cpsr_o[W-1:MODE_W])));

  // R7
  entry_save_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_enter && has_slot(exc_mode)) |=> (spsr_o == $past(cpsr_o)));

  // R8
  ret_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_return && !exc_enter && !csr_we && no_slot_mode) |=> $stable(cpsr_o));

  // R11
  spsr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    no_slot_mode |-> (spsr_o == '0));

endmodule

bind banked_regfile banked_regfile_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .pc_in      (pc_in),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .br_valid   (br_valid),
  .br_target  (br_target),
  .exc_enter  (exc_enter),
  .exc_mode   (exc_mode),
  .exc_return (exc_return),
  .csr_we     (csr_we),
  .cpsr_o     (cpsr_o),
  .spsr_o     (spsr_o)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

  localparam logic [4:0] MU = 5'b10000;
  localparam logic [4:0] MF = 5'b10001;
  localparam logic [4:0] MI = 5'b10010;
  localparam logic [4:0] MS = 5'b10011;
  localparam logic [4:0] MA = 5'b10111;
  localparam logic [4:0] MD = 5'b11011;
  localparam logic [4:0] MY = 5'b11111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, br_target, cpsr_o, spsr_o;
  logic [31:0] pc_in = '0, wr_data = '0, csr_wdata = '0;
  logic        wr_en = 1'b0, exc_enter = 1'b0, exc_return = 1'b0, csr_we = 1'b0;
  logic [4:0]  exc_mode = '0;
  logic        br_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  banked_regfile #(.W(32)) u_banked_regfile (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .pc_in(pc_in), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .br_valid(br_valid), .br_target(br_target),
    .exc_enter(exc_enter), .exc_mode(exc_mode), .exc_return(exc_return),
    .csr_we(csr_we), .csr_wdata(csr_wdata),
    .cpsr_o(cpsr_o), .spsr_o(spsr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic set_status(input logic [31:0] w);
    csr_we = 1'b1; csr_wdata = w; cyc(); csr_we = 1'b0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    set_status({27'h0, m});
  endtask

  task automatic wreg(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] i, output logic [31:0] d);
    rd_a_idx = i; cyc(); d = rd_a_data;
  endtask

  task automatic t_reset();
    check("R1 cpsr", cpsr_o, 32'h0000_0013);
    check("R1 spsr", spsr_o, 32'h0);
    check("R1 br_valid", {31'h0, br_valid}, 32'h0);
    check("R1 rd_a", rd_a_data, 32'h0);
    check("R1 rd_b", rd_b_data, 32'h0);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    set_mode(MS); wreg(4'd3, 32'h3333_0001);
    set_mode(MF); rreg(4'd3, d); check("R2 r3 svc->fiq", d, 32'h3333_0001);
    set_mode(MD); wreg(4'd7, 32'h7777_0002);
    set_mode(MU); rreg(4'd7, d); check("R2 r7 und->usr", d, 32'h7777_0002);
  endtask

  task automatic t_fiq_hi();
    logic [31:0] d;
    set_mode(MU); wreg(4'd8, 32'h0808_0000); wreg(4'd12, 32'h0C0C_0000);
    set_mode(MF); wreg(4'd8, 32'h0808_F1F1);
    rreg(4'd8, d);  check("R3 fiq r8", d, 32'h0808_F1F1);
    set_mode(MI);
    rreg(4'd8, d);  check("R3 irq r8 common", d, 32'h0808_0000);
    rreg(4'd12, d); check("R3 irq r12 common", d, 32'h0C0C_0000);
    set_mode(MY);
    rreg(4'd8, d);  check("R3 sys r8 common", d, 32'h0808_0000);
  endtask

  task automatic t_sp_lr();
    logic [4:0]  modes [6] = '{MU, MF, MI, MS, MA, MD};
    logic [31:0] d;
    for (int k = 0; k < 6; k++) begin
      set_mode(modes[k]);
      wreg(4'd13, 32'h1300_0000 | k);
      wreg(4'd14, 32'h1400_0000 | k);
    end
    for (int k = 0; k < 6; k++) begin
      set_mode(modes[k]);
      rreg(4'd13, d); check($sformatf("R4 r13 bank %0d", k), d, 32'h1300_0000 | k);
      rreg(4'd14, d); check($sformatf("R4 r14 bank %0d", k), d, 32'h1400_0000 | k);
    end
    set_mode(MY);
    rreg(4'd13, d); check("R4 sys r13 = usr", d, 32'h1300_0000);
  endtask

  task automatic t_pc_read();
    pc_in = 32'hDEAD_B000; rd_a_idx = 4'd15; rd_b_idx = 4'd3;
    cyc();
    pc_in = 32'h0000_1234;
    check("R5 r15 read", rd_a_data, 32'hDEAD_B000);
    check("R5 port b", rd_b_data, 32'h3333_0001);
    cyc();
    check("R5 r15 resample", rd_a_data, 32'h0000_1234);
  endtask

  task automatic t_branch();
    logic [31:0] d;
    set_mode(MF);
    wreg(4'd15, 32'h0040_0100);
    check("R6 br_valid", {31'h0, br_valid}, 32'h1);
    check("R6 br_target", br_target, 32'h0040_0100);
    cyc();
    check("R6 pulse ends", {31'h0, br_valid}, 32'h0);
    rreg(4'd8, d); check("R6 fiq r8 untouched", d, 32'h0808_F1F1);
  endtask

  task automatic t_entry();
    set_status(32'hA000_0010);
    check("R10 direct write", cpsr_o, 32'hA000_0010);
    check("R11 user spsr zero", spsr_o, 32'h0);
    exc_enter = 1'b1; exc_mode = MI; cyc(); exc_enter = 1'b0;
    check("R7 entry cpsr", cpsr_o, 32'hA000_0012);
    check("R7 entry saved", spsr_o, 32'hA000_0010);
    exc_enter = 1'b1; exc_mode = MU; cyc();
    exc_mode = 5'b00000; cyc(); exc_enter = 1'b0;
    check("R7 bad target ignored", cpsr_o, 32'hA000_0012);
  endtask

  task automatic t_return();
    set_status(32'h5000_0012);
    check("R10 saved untouched", spsr_o, 32'hA000_0010);
    exc_return = 1'b1; cyc(); exc_return = 1'b0;
    check("R8 return", cpsr_o, 32'hA000_0010);
    check("R11 spsr after return", spsr_o, 32'h0);
    exc_return = 1'b1; cyc(); exc_return = 1'b0;
    check("R8 ignored in user", cpsr_o, 32'hA000_0010);
    set_status(32'h0000_001F);
    exc_return = 1'b1; cyc(); exc_return = 1'b0;
    check("R8 ignored in system", cpsr_o, 32'h0000_001F);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    set_status(32'h3000_0013);
    exc_enter = 1'b1; exc_mode = MA; exc_return = 1'b1;
    csr_we = 1'b1; csr_wdata = 32'hFFFF_FFFF;
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h0000_AB13;
    cyc();
    exc_enter = 1'b0; wr_en = 1'b0;
    check("R9 entry wins", cpsr_o, 32'h3000_0017);
    check("R9 entry saved", spsr_o, 32'h3000_0013);
    cyc();
    check("R9 return over write", cpsr_o, 32'h3000_0013);
    exc_return = 1'b0; csr_we = 1'b0;
    set_mode(MA);
    rreg(4'd13, d); check("R9 abt r13 kept", d, 32'h1300_0004);
    set_mode(MS);
    rreg(4'd13, d); check("R9 write in old bank", d, 32'h0000_AB13);
  endtask

  task automatic t_same_cycle();
    set_mode(MU);
    wreg(4'd2, 32'h0202_0001);
    rd_a_idx = 4'd2;
    wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h0202_0002;
    cyc(); wr_en = 1'b0;
    check("R12 old value", rd_a_data, 32'h0202_0001);
    cyc();
    check("R12 new value", rd_a_data, 32'h0202_0002);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst = 1'b0;
    cyc();
    t_shared();
    t_fiq_hi();
    t_sp_lr();
    t_pc_read();
    t_branch();
    t_entry();
    t_return();
    t_priority();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule